// File: doc/BRIEF.md
# Multi-Ramp Power Stage PWM

This block produces a pair of pulse-width-modulated drive signals, A and B, for a switching power stage. A single counter steps through a repeating sequence of ramps, and each ramp ends at one of four 16-bit compare values: dead time A, on time A, dead time B and on time B. A two-bit mode picks the sequence. The sequence can be one ramp, two ramps, four ramps, or a centre-aligned count that rises and then falls. A prescaler slows the counter to one step every 1, 4, 16 or 64 clocks.

Each output has its own enable, and one polarity bit sets the active level of both. The block gives a one-clock pulse at the end of every complete cycle. It also gives a strobe that can start an ADC conversion on a chosen edge of A or B. Software can stop the generator at once, or ask it to finish the current cycle first and then halt.

Top module: `ramp_pwm`

## Requirements
- R1: While reset is asserted and after it is released with run low, both outputs sit at their inactive level (the inverse of `polHigh`), and `cycleEnd` and `adcSync` are low.
- R2: `preSel` sets how many clocks the counter waits per step: 00 is 1 clock, 01 is 4, 10 is 16 and 11 is 64.
- R3: Mode 00 counts 0 up to `onB` and then restarts, so a cycle is `onB`+1 steps. A is active while the count is below `onA`. B is active while the count is above `deadB`.
- R4: Mode 01 counts 0 to `onA` with A active, then counts 0 to `onB` with B active. A cycle is `onA`+`onB`+2 steps.
- R5: Mode 10 runs four ramps, each counted from 0, in the order dead A, on A, dead B, on B. A is active only in the on-A ramp and B only in the on-B ramp. Neither output is active during a dead ramp. A and B are never active together in modes 01 and 10.
- R6: Mode 11 counts 0 up to `onB` and back down towards 0, so a cycle is 2·`onB` steps (1 step when `onB` is 0). A and B use the same count comparisons as in R3.
- R7: `cycleEnd` is high for exactly one clock. It rises the clock after the step that completes the last ramp, or after the step that returns the centre-aligned count to 0.
- R8: `syncSel` picks the strobe source: 00 is A becoming active, 01 is A becoming inactive, 10 is B becoming active and 11 is B becoming inactive. The strobe lasts one clock and follows the internal activity of the output whatever the enable or polarity.
- R9: An active output is driven to `polHigh`. An inactive output, or one whose enable is low, is driven to the inverse of `polHigh`.
- R10: With `runEn` low and `finishReq` high, the generator keeps running to the end of the current cycle. It then holds at the start with both outputs inactive.
- R11: With `runEn` and `finishReq` both low, the counter returns to the start on the next clock. From the following clock on, both outputs are inactive and `cycleEnd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run the generator |
| finishReq | input | 1 | When run is low, finish the cycle before halting |
| modeSel | input | 2 | Ramp sequence select |
| preSel | input | 2 | Prescaler select |
| syncSel | input | 2 | ADC strobe source select |
| polHigh | input | 1 | 1 = outputs active high |
| enA | input | 1 | Enable for output A |
| enB | input | 1 | Enable for output B |
| deadA | input | 16 | Dead time A compare |
| onA | input | 16 | On time A compare |
| deadB | input | 16 | Dead time B compare |
| onB | input | 16 | On time B compare |
| pwmA | output | 1 | Drive output A |
| pwmB | output | 1 | Drive output B |
| cycleEnd | output | 1 | One-clock end-of-cycle pulse |
| adcSync | output | 1 | ADC trigger strobe |

## Verification
The bench goes after ramps of zero length, where a compare value of 0 still costs one step; an off-by-one at the ramp limit shifts every later edge and breaks the cycle length. It checks a centre-aligned peak of 0, 1 and higher values. A turnaround that spends an extra step at the bottom, or counts the peak twice, would make the cycle too long and would misplace `cycleEnd`. It checks the slow prescaler settings, where a wrong divisor stretches or shrinks every ramp. It stops the generator mid-cycle in both ways. A finish request that halts at once, or runs past the cycle boundary, would show extra or missing output pulses. A sync mux with its edge senses swapped would strobe on the opposite edge.

// File: rtl/ramp_pwm_pkg.sv
package ramp_pwm_pkg;
  localparam int PRE_W = 6;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_FOUR = 2'b10,
    MODE_CTR  = 2'b11
  } rampMode_e;

  typedef struct packed {
    logic       live;
    logic [1:0] phase;
  } seqStrb_t;
endpackage

// File: rtl/ramp_pwm_ctrl.sv
module ramp_pwm_ctrl
  import ramp_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic          finishReq,
  input  logic [1:0]    modeSel,
  input  logic [1:0]    preSel,
  input  logic [CW-1:0] deadA,
  input  logic [CW-1:0] onA,
  input  logic [CW-1:0] deadB,
  input  logic [CW-1:0] onB,
  output seqStrb_t      strb,
  output logic [CW-1:0] cnt,
  output logic          cycleEnd
);
  rampMode_e      mode;
  logic [CW-1:0]  cntQ, cntD, limit;
  logic [1:0]     phQ, phD, lastPh;
  logic           downQ, downD, wrap;
  logic [PRE_W-1:0] preQ, preLast;
  logic           endQ, atStart, live, stopNow, tick;

  assign mode    = rampMode_e'(modeSel);
  assign preLast = PRE_W'((1 << (2 * int'(preSel))) - 1);
  assign atStart = (cntQ == '0) && (phQ == 2'd0) && !downQ;
  assign stopNow = !runEn && !finishReq;
  assign live    = runEn || (finishReq && !atStart);
  assign tick    = live && (preQ == preLast);

  // ramp limit and last ramp of the sequence
  always_comb begin
    limit  = onB;
    lastPh = 2'd0;
    case (mode)
      MODE_TWO: begin
        limit  = phQ[0] ? onB : onA;
        lastPh = 2'd1;
      end
      MODE_FOUR: begin
        lastPh = 2'd3;
        case (phQ)
          2'd0:    limit = deadA;
          2'd1:    limit = onA;
          2'd2:    limit = deadB;
          default: limit = onB;
        endcase
      end
      default: ;
    endcase
  end

  // next counter state for one step
  always_comb begin
    cntD  = cntQ;
    phD   = phQ;
    downD = downQ;
    wrap  = 1'b0;
    if (mode == MODE_CTR) begin
      phD = 2'd0;
      if (!downQ) begin
        if (cntQ >= onB) begin
          if (cntQ <= 1) begin
            cntD = '0;
            wrap = 1'b1;
          end else begin
            downD = 1'b1;
            cntD  = cntQ - 1'b1;
          end
        end else begin
          cntD = cntQ + 1'b1;
        end
      end else if (cntQ <= 1) begin
        cntD  = '0;
        downD = 1'b0;
        wrap  = 1'b1;
      end else begin
        cntD = cntQ - 1'b1;
      end
    end else if (cntQ >= limit) begin
      cntD = '0;
      if (phQ >= lastPh) begin
        phD  = 2'd0;
        wrap = 1'b1;
      end else begin
        phD = phQ + 2'd1;
      end
    end else begin
      cntD = cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stopNow) begin
      cntQ  <= '0;
      phQ   <= 2'd0;
      downQ <= 1'b0;
      preQ  <= '0;
      endQ  <= 1'b0;
    end else if (live) begin
      preQ <= tick ? '0 : preQ + 1'b1;
      endQ <= tick && wrap;
      if (tick) begin
        cntQ  <= cntD;
        phQ   <= phD;
        downQ <= downD;
      end
    end else begin
      preQ <= '0;
      endQ <= 1'b0;
    end
  end

  always_comb begin
    strb.live  = live;
    strb.phase = phQ;
  end
  assign cnt      = cntQ;
  assign cycleEnd = endQ;
endmodule

// File: rtl/ramp_pwm_dp.sv
module ramp_pwm_dp
  import ramp_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrb_t      strb,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    modeSel,
  input  logic [CW-1:0] onA,
  input  logic [CW-1:0] deadB,
  input  logic          polHigh,
  input  logic          enA,
  input  logic          enB,
  input  logic [1:0]    syncSel,
  output logic          pwmA,
  output logic          pwmB,
  output logic          adcSync,
  output logic [1:0]    actVec
);
  localparam int NCH = 2;

  rampMode_e      mode;
  logic [NCH-1:0] raw, actD, enVec, pwmVec;
  logic           selAct, selActD;

  assign mode  = rampMode_e'(modeSel);
  assign enVec = {enB, enA};

  // bit 0 = output A, bit 1 = output B
  always_comb begin
    case (mode)
      MODE_TWO:  raw = {strb.phase == 2'd1, strb.phase == 2'd0};
      MODE_FOUR: raw = {strb.phase == 2'd3, strb.phase == 2'd1};
      default:   raw = {cnt > deadB, cnt < onA};
    endcase
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    logic actR, actDR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actR  <= 1'b0;
        actDR <= 1'b0;
      end else begin
        actR  <= strb.live && raw[ch];
        actDR <= actR;
      end
    end
    assign actVec[ch] = actR;
    assign actD[ch]   = actDR;
    assign pwmVec[ch] = (actR && enVec[ch]) ? polHigh : !polHigh;
  end

  assign selAct  = actVec[syncSel[1]];
  assign selActD = actD[syncSel[1]];
  assign adcSync = syncSel[0] ? (!selAct && selActD) : (selAct && !selActD);
  assign pwmA    = pwmVec[0];
  assign pwmB    = pwmVec[1];
endmodule

// File: rtl/ramp_pwm.sv
module ramp_pwm
  import ramp_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic          finishReq,
  input  logic [1:0]    modeSel,
  input  logic [1:0]    preSel,
  input  logic [1:0]    syncSel,
  input  logic          polHigh,
  input  logic          enA,
  input  logic          enB,
  input  logic [CW-1:0] deadA,
  input  logic [CW-1:0] onA,
  input  logic [CW-1:0] deadB,
  input  logic [CW-1:0] onB,
  output logic          pwmA,
  output logic          pwmB,
  output logic          cycleEnd,
  output logic          adcSync
);
  seqStrb_t      strb;
  logic [CW-1:0] cnt;
  logic [1:0]    actVec;

  ramp_pwm_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .finishReq(finishReq),
    .modeSel(modeSel), .preSel(preSel), .deadA(deadA), .onA(onA),
    .deadB(deadB), .onB(onB), .strb(strb), .cnt(cnt), .cycleEnd(cycleEnd)
  );

  ramp_pwm_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .modeSel(modeSel),
    .onA(onA), .deadB(deadB), .polHigh(polHigh), .enA(enA), .enB(enB),
    .syncSel(syncSel), .pwmA(pwmA), .pwmB(pwmB), .adcSync(adcSync),
    .actVec(actVec)
  );
endmodule

// File: rtl/ramp_pwm_chk.sv
module ramp_pwm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       runEn,
  input logic       finishReq,
  input logic [1:0] modeSel,
  input logic [1:0] preSel,
  input logic       polHigh,
  input logic       enA,
  input logic [1:0] syncSel,
  input logic       pwmA,
  input logic       cycleEnd,
  input logic       adcSync,
  input logic [1:0] actVec
);
  // R9
  disabled_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enA |-> (pwmA == !polHigh));

  // R11
  hard_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !finishReq) |=> (actVec == 2'b00 && !cycleEnd));

  // R8
  sync_lead_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcSync && syncSel == 2'b00) |-> actVec[0]);

  // R8
  sync_trail_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcSync && syncSel == 2'b11) |-> !actVec[1]);

  // R7
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && preSel != 2'b00) |=> !cycleEnd);

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 || modeSel == 2'b10) |-> !(actVec[0] && actVec[1]));
endmodule

bind ramp_pwm ramp_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .finishReq(finishReq),
  .modeSel(modeSel), .preSel(preSel), .polHigh(polHigh), .enA(enA),
  .syncSel(syncSel), .pwmA(pwmA), .cycleEnd(cycleEnd), .adcSync(adcSync),
  .actVec(actVec)
);

// File: tb/test_ramp_pwm.sv
`timescale 1ns/1ps
module test_ramp_pwm;
  logic        clk = 1'b0;
  logic        rstN, runEn, finishReq, polHigh, enA, enB;
  logic [1:0]  modeSel, preSel, syncSel;
  logic [15:0] deadA, onA, deadB, onB;
  logic        pwmA, pwmB, cycleEnd, adcSync;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int       mPos, mPre;
  logic [1:0] mAct, mActD;
  logic     mEnd;

  always #2.5 clk = ~clk;

  ramp_pwm i_ramp_pwm (
    .clk(clk), .rstN(rstN), .runEn(runEn), .finishReq(finishReq),
    .modeSel(modeSel), .preSel(preSel), .syncSel(syncSel), .polHigh(polHigh),
    .enA(enA), .enB(enB), .deadA(deadA), .onA(onA), .deadB(deadB), .onB(onB),
    .pwmA(pwmA), .pwmB(pwmB), .cycleEnd(cycleEnd), .adcSync(adcSync)
  );

  function automatic int cycLen();
    case (modeSel)
      2'b00:   return int'(onB) + 1;
      2'b01:   return int'(onA) + int'(onB) + 2;
      2'b10:   return int'(deadA) + int'(onA) + int'(deadB) + int'(onB) + 4;
      default: return (onB == 0) ? 1 : 2 * int'(onB);
    endcase
  endfunction

  // bit 0 = A, bit 1 = B, activity at a position within the cycle
  function automatic logic [1:0] rawAt(int pos);
    int c;
    case (modeSel)
      2'b01: return (pos <= int'(onA)) ? 2'b01 : 2'b10;
      2'b10: begin
        if (pos < int'(deadA) + 1) return 2'b00;
        if (pos < int'(deadA) + int'(onA) + 2) return 2'b01;
        if (pos < int'(deadA) + int'(onA) + int'(deadB) + 3) return 2'b00;
        return 2'b10;
      end
      default: begin
        c = (modeSel == 2'b11 && pos > int'(onB)) ? 2 * int'(onB) - pos : pos;
        return {c > int'(deadB), c < int'(onA)};
      end
    endcase
  endfunction

  always @(posedge clk) begin
    bit live, tick;
    int len;
    if (!rstN) begin
      mPos = 0; mPre = 0; mAct = 2'b00; mActD = 2'b00; mEnd = 1'b0;
    end else begin
      live  = runEn || (finishReq && mPos != 0);
      mActD = mAct;
      mAct  = live ? rawAt(mPos) : 2'b00;
      if (!runEn && !finishReq) begin
        mPos = 0; mPre = 0; mEnd = 1'b0;
      end else if (live) begin
        len  = cycLen();
        tick = (mPre == (1 << (2 * int'(preSel))) - 1);
        mPre = tick ? 0 : mPre + 1;
        mEnd = tick && (mPos + 1 >= len);
        if (tick) mPos = (mPos + 1 >= len) ? 0 : mPos + 1;
      end else begin
        mPre = 0; mEnd = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic runClocks(input int n, input string tag);
    logic expSync, a, ad;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a  = mAct[syncSel[1]];
      ad = mActD[syncSel[1]];
      expSync = syncSel[0] ? (!a && ad) : (a && !ad);
      chk(tag, "pwmA", pwmA, (mAct[0] && enA) ? polHigh : !polHigh);
      chk(tag, "pwmB", pwmB, (mAct[1] && enB) ? polHigh : !polHigh);
      chk("R7", "cycleEnd", cycleEnd, mEnd);
      chk("R8", "adcSync", adcSync, expSync);
    end
  endtask

  task automatic runCase(input logic [1:0] m, input logic [1:0] p, input logic [1:0] s,
                         input int a, input int b, input int c, input int d,
                         input logic pol, input logic ea, input logic eb,
                         input int n, input string tag);
    runEn = 0; finishReq = 0;
    modeSel = m; preSel = p; syncSel = s;
    deadA = 16'(a); onA = 16'(b); deadB = 16'(c); onB = 16'(d);
    polHigh = pol; enA = ea; enB = eb;
    runClocks(2, tag);
    runEn = 1;
    runClocks(n, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    string tags[4];
    int len;
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";
    rstN = 0; runEn = 0; finishReq = 0; modeSel = 0; preSel = 0; syncSel = 0;
    polHigh = 0; enA = 1; enB = 1; deadA = 0; onA = 0; deadB = 0; onB = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pwmA", pwmA, 1'b1);
    chk("R1", "pwmB", pwmB, 1'b1);
    chk("R1", "cycleEnd", cycleEnd, 1'b0);
    chk("R1", "adcSync", adcSync, 1'b0);
    rstN = 1;
    runClocks(4, "R1");

    // R3 R4 R5 R6 mode sweeps with small compares
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          runCase(2'(m), 2'b00, 2'(a + b), a, b + 1, b, a + b, 1'(b), 1, 1, 40, tags[m]);
        end

    // R2 prescaler settings
    runCase(2'b01, 2'b01, 2'b00, 0, 2, 0, 1, 1, 1, 1, 120, "R2");
    runCase(2'b10, 2'b10, 2'b11, 0, 1, 1, 0, 1, 1, 1, 320, "R2");
    runCase(2'b00, 2'b11, 2'b01, 0, 1, 0, 2, 0, 1, 1, 450, "R2");

    // R9 polarity and enables
    runCase(2'b01, 2'b00, 2'b10, 0, 2, 0, 3, 1, 0, 1, 30, "R9");
    runCase(2'b11, 2'b00, 2'b01, 0, 2, 1, 4, 0, 1, 0, 30, "R9");

    // R10 finish the cycle, then hold
    runCase(2'b10, 2'b00, 2'b10, 1, 2, 1, 3, 1, 1, 1, 7, "R10");
    len = cycLen();
    finishReq = 1; runEn = 0;
    runClocks(3 * len, "R10");
    runCase(2'b11, 2'b01, 2'b00, 0, 2, 1, 3, 1, 1, 1, 9, "R10");
    finishReq = 1; runEn = 0;
    runClocks(80, "R10");

    // R11 immediate stop mid-cycle
    runCase(2'b01, 2'b00, 2'b11, 0, 3, 0, 4, 1, 1, 1, 6, "R11");
    runEn = 0; finishReq = 0;
    runClocks(12, "R11");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule